// File: doc/BRIEF.md
# Eight-Channel Serial Telemetry Responder

This block answers requests on eight balanced serial acquisition links. On each link a remote requester drives a bit clock and an envelope line that frames one transfer. While the envelope is active, the block shifts out a fixed 16-bit reply word on that link's data line. The data moves in step with the requester's clock. All eight links run at the same time and do not depend on each other.

A host loads the reply word for each channel through a write port. The host can also read a flag register that clears on read. The flags report frames that ended early and frames that carried too many clocks. The requester clock and envelope are asynchronous to the system clock. They pass through two-flop synchronisers, and edge detection happens in the system clock domain. The system clock must run at least eight times faster than any link clock.

Top module: `telem_resp_top`

## Requirements
- R1: During and right after reset, every data line is low, the status word is zero and every reply register holds zero.
- R2: A frame sends the 16-bit word captured at envelope assertion, most significant bit first. Bit k is launched after the k-th rising edge of the link clock inside the envelope, and appears on the data line no more than three system clocks after that edge.
- R3: While a channel's envelope is inactive, its data line is low.
- R4: The reply register is copied at envelope assertion. A host write to the same channel during a frame changes only later frames.
- R5: If the envelope drops after fewer than 16 link clock rises, the data line returns low and status bit `ch` (bits 7:0) is set.
- R6: Each link clock rise after the sixteenth within one envelope drives the data line low and sets status bit `8+ch` (bits 15:8).
- R7: All eight channels can carry frames at the same time, each with its own word and no crosstalk.
- R8: Status flags stay set until the host pulses `stat_rd_i`. That pulse clears them, but an event in the same cycle is kept.
- R9: A write with `wr_en_i` high loads `wr_data_i` into the reply register chosen by the 3-bit `wr_chan_i`. Other channels are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Reply register write strobe |
| wr_chan_i | input | 3 | Channel addressed by the write |
| wr_data_i | input | 16 | Reply word to store |
| stat_rd_i | input | 1 | Status read strobe; clears flags |
| stat_o | output | 16 | {overrun[7:0], short_frame[7:0]} |
| link_clk_i | input | 8 | Requester bit clock, one per channel |
| link_env_i | input | 8 | Requester envelope, one per channel |
| link_dat_o | output | 8 | Reply data line, one per channel |

## Verification
The bench sends frames of 0, 10, 16, 17 and 20 clocks. A frame of 0 clocks catches a design that flags short frames only after some bits went out. A frame of 17 clocks catches an off-by-one in the overrun limit that would leak one more reply bit. The bench writes a new word to a channel in the middle of its frame. A design that shifts the live register instead of a snapshot would corrupt the word already in flight. It also runs all eight channels at once with distinct words, which shows up shared state or a wrong channel index as swapped or mixed words. After each frame it checks that the data line is low and that a status read leaves the flags at zero.

// File: rtl/tr_pkg.sv
package tr_pkg;
  localparam int unsigned NCH_DEF    = 8;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/tr_sync.sv
module tr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tr_lane.sv
module tr_lane #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lclk_i,
  input  logic              env_i,
  input  logic [WORD_W-1:0] reply_i,
  output logic              dat_o,
  output logic              short_o,
  output logic              over_o
);
  logic              lclk_q, env_q, busy_q, dat_q, short_q, over_q;
  logic [WORD_W-1:0] sh_q, sh_n, sh_b;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_b;
  logic              busy_n, busy_b, dat_n, short_n, over_n;
  logic              env_rise, clk_rise;

  assign env_rise = env_i & ~env_q;
  assign clk_rise = lclk_i & ~lclk_q;

  always_comb begin
    sh_b    = env_rise ? reply_i : sh_q;
    cnt_b   = env_rise ? '0 : cnt_q;
    busy_b  = env_rise | busy_q;
    sh_n    = sh_b;
    cnt_n   = cnt_b;
    busy_n  = busy_b;
    dat_n   = env_rise ? 1'b0 : dat_q;
    short_n = 1'b0;
    over_n  = 1'b0;
    if (!env_i) begin
      busy_n  = 1'b0;
      dat_n   = 1'b0;
      short_n = busy_q && (cnt_q < CNT_W'(WORD_W));
    end else if (busy_b && clk_rise) begin
      if (cnt_b < CNT_W'(WORD_W)) begin
        dat_n = sh_b[WORD_W-1];
        sh_n  = {sh_b[WORD_W-2:0], 1'b0};
        cnt_n = cnt_b + 1'b1;
      end else begin
        dat_n  = 1'b0;
        over_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lclk_q  <= 1'b0;
      env_q   <= 1'b0;
      busy_q  <= 1'b0;
      dat_q   <= 1'b0;
      short_q <= 1'b0;
      over_q  <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      lclk_q  <= lclk_i;
      env_q   <= env_i;
      busy_q  <= busy_n;
      dat_q   <= dat_n;
      short_q <= short_n;
      over_q  <= over_n;
      sh_q    <= sh_n;
      cnt_q   <= cnt_n;
    end
  end

  assign dat_o   = dat_q;
  assign short_o = short_q;
  assign over_o  = over_q;
endmodule

// File: rtl/tr_status.sv
module tr_status #(
  parameter int unsigned NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   short_i,
  input  logic [NCH-1:0]   over_i,
  input  logic             rd_i,
  output logic [2*NCH-1:0] flags_o
);
  logic [NCH-1:0] short_q, over_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_q <= '0;
      over_q  <= '0;
    end else begin
      // new events win over a same-cycle clear
      short_q <= (short_q & {NCH{~rd_i}}) | short_i;
      over_q  <= (over_q  & {NCH{~rd_i}}) | over_i;
    end
  end

  assign flags_o = {over_q, short_q};
endmodule

// File: rtl/telem_resp_top.sv
module telem_resp_top
  import tr_pkg::*;
#(
  parameter int unsigned NCH    = NCH_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SYNC   = SYNC_DEF,
  localparam int unsigned CH_W  = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic [2*NCH-1:0]  stat_o,
  input  logic [NCH-1:0]    link_clk_i,
  input  logic [NCH-1:0]    link_env_i,
  output logic [NCH-1:0]    link_dat_o
);
  logic [NCH-1:0] clk_s, env_s, short_p, over_p;

  tr_sync #(.W(2*NCH), .STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({link_clk_i, link_env_i}),
    .q_o    ({clk_s, env_s})
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WORD_W-1:0] reply_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reply_q <= '0;
      else if (wr_en_i && wr_chan_i == CH_W'(c)) reply_q <= wr_data_i;
    end

    tr_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lclk_i  (clk_s[c]),
      .env_i   (env_s[c]),
      .reply_i (reply_q),
      .dat_o   (link_dat_o[c]),
      .short_o (short_p[c]),
      .over_o  (over_p[c])
    );
  end

  tr_status #(.NCH(NCH)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .short_i (short_p),
    .over_i  (over_p),
    .rd_i    (stat_rd_i),
    .flags_o (stat_o)
  );
endmodule

// File: rtl/tr_chk.sv
module tr_chk #(
  parameter int unsigned NCH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stat_rd_i,
  input logic [2*NCH-1:0] stat_o,
  input logic [NCH-1:0]   link_env_i,
  input logic [NCH-1:0]   link_dat_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (link_dat_o == '0 && stat_o == '0);
  end

  // R8
  flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    env_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!link_env_i[c] && !$past(link_env_i[c]) && !$past(link_env_i[c], 2))
      |=> !link_dat_o[c]);

    // R5
    short_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_o[c]) |-> !link_dat_o[c]);

    // R6
    over_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_o[NCH+c]) |-> !link_dat_o[c]);
  end
endmodule

bind telem_resp_top tr_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stat_rd_i  (stat_rd_i),
  .stat_o     (stat_o),
  .link_env_i (link_env_i),
  .link_dat_o (link_dat_o)
);

// File: tb/telem_resp_top_test.sv
module telem_resp_top_test;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_chan_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        stat_rd_i = 1'b0;
  logic [15:0] stat_o;
  logic [7:0]  link_clk_i = '0;
  logic [7:0]  link_env_i = '0;
  logic [7:0]  link_dat_o;

  int total = 0;
  int fails = 0;
  logic [15:0] got [8];
  logic        extra [8];

  always #10 clk = ~clk;

  telem_resp_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_chan_i(wr_chan_i),
    .wr_data_i(wr_data_i), .stat_rd_i(stat_rd_i), .stat_o(stat_o),
    .link_clk_i(link_clk_i), .link_env_i(link_env_i), .link_dat_o(link_dat_o)
  );

  // {channel, word, clock count}
  localparam logic [24:0] VECS [8] = '{
    {3'd0, 16'hA5C3, 6'd16},
    {3'd1, 16'h8001, 6'd16},
    {3'd2, 16'hFFFF, 6'd16},
    {3'd3, 16'h1234, 6'd10},
    {3'd4, 16'h0F0F, 6'd20},
    {3'd5, 16'h7FFE, 6'd16},
    {3'd6, 16'h5A5A, 6'd0},
    {3'd7, 16'hC0DE, 6'd17}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ch, input logic [15:0] v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_chan_i = ch; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_clear();
    @(negedge clk);
    stat_rd_i = 1'b1;
    @(negedge clk);
    stat_rd_i = 1'b0;
  endtask

  task automatic frame(input logic [7:0] m, input int n, input bit midw,
                       input logic [2:0] wch, input logic [15:0] wval);
    for (int c = 0; c < 8; c++) begin got[c] = '0; extra[c] = 1'b0; end
    @(negedge clk);
    link_env_i = link_env_i | m;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      link_clk_i = link_clk_i | m;
      repeat (H) @(negedge clk);
      for (int c = 0; c < 8; c++) if (m[c]) begin
        if (i < 16) got[c][15-i] = link_dat_o[c];
        else extra[c] = extra[c] | link_dat_o[c];
      end
      link_clk_i = link_clk_i & ~m;
      if (midw && i == 4) begin
        wr_en_i = 1'b1; wr_chan_i = wch; wr_data_i = wval;
        @(negedge clk);
        wr_en_i = 1'b0;
      end
      repeat (H) @(negedge clk);
    end
    link_env_i = link_env_i & ~m;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] mask, expw, exps;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(link_dat_o == 8'h00, "R1 data", {24'h0, link_dat_o}, 32'h0);
    chk(stat_o == 16'h0, "R1 status", {16'h0, stat_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reply registers clear: frame on ch2 with no write sends zeros
    frame(8'h04, 16, 1'b0, 3'd0, 16'h0);
    chk(got[2] == 16'h0, "R1 reply reset", {16'h0, got[2]}, 32'h0);

    for (int v = 0; v < 8; v++) begin
      logic [2:0] ch;
      logic [15:0] w;
      int n;
      ch = VECS[v][24:22]; w = VECS[v][21:6]; n = int'(VECS[v][5:0]);
      wr(ch, w);
      frame(8'h01 << ch, n, 1'b0, 3'd0, 16'h0);
      mask = (n >= 16) ? 16'hFFFF : ~(16'hFFFF >> n);
      expw = w & mask;
      chk(got[ch] == expw, (n < 16) ? "R5 partial word" : "R2 word",
          {16'h0, got[ch]}, {16'h0, expw});
      chk(extra[ch] == 1'b0, "R6 extra bits low", {31'h0, extra[ch]}, 32'h0);
      chk(link_dat_o[ch] == 1'b0, "R3 idle low", {31'h0, link_dat_o[ch]}, 32'h0);
      exps = '0;
      if (n < 16) exps[ch] = 1'b1;
      if (n > 16) exps[8+ch] = 1'b1;
      chk(stat_o == exps, (n > 16) ? "R6 overrun flag" : "R5 short flag",
          {16'h0, stat_o}, {16'h0, exps});
      rd_clear();
      chk(stat_o == 16'h0, "R8 read clear", {16'h0, stat_o}, 32'h0);
    end

    // R7 all channels concurrently
    for (int c = 0; c < 8; c++) wr(3'(c), 16'h1357 ^ (16'(c) * 16'h2461));
    frame(8'hFF, 16, 1'b0, 3'd0, 16'h0);
    for (int c = 0; c < 8; c++) begin
      expw = 16'h1357 ^ (16'(c) * 16'h2461);
      chk(got[c] == expw, "R7 concurrent", {16'h0, got[c]}, {16'h0, expw});
    end
    chk(stat_o == 16'h0, "R7 no flags", {16'h0, stat_o}, 32'h0);

    // R9 write only touches addressed channel
    wr(3'd2, 16'hDEAD);
    frame(8'h0C, 16, 1'b0, 3'd0, 16'h0);
    chk(got[2] == 16'hDEAD, "R9 addressed", {16'h0, got[2]}, 32'h0000DEAD);
    expw = 16'h1357 ^ (16'd3 * 16'h2461);
    chk(got[3] == expw, "R9 neighbour kept", {16'h0, got[3]}, {16'h0, expw});

    // R4 mid-frame write affects next frame only
    wr(3'd1, 16'h6C93);
    frame(8'h02, 16, 1'b1, 3'd1, 16'hBEEF);
    chk(got[1] == 16'h6C93, "R4 snapshot", {16'h0, got[1]}, 32'h00006C93);
    frame(8'h02, 16, 1'b0, 3'd0, 16'h0);
    chk(got[1] == 16'hBEEF, "R4 next frame", {16'h0, got[1]}, 32'h0000BEEF);

    // R8 flags sticky until read
    frame(8'h10, 5, 1'b0, 3'd0, 16'h0);
    repeat (20) @(negedge clk);
    chk(stat_o == 16'h0010, "R8 sticky", {16'h0, stat_o}, 32'h0010);
    rd_clear();
    chk(stat_o == 16'h0, "R8 cleared", {16'h0, stat_o}, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule